// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block remembers where recently taken control transfers went, keyed by the address of the instruction pair that leads up to them. A fetch stage presents a 32-bit pair address and receives, one clock later, whether a live entry exists, whether that entry calls for a redirect, and the remembered destination. Storage is 64 sets of 4 ways (256 entries). Each entry keeps an address tag, a destination and a 2-bit saturating confidence counter. A counter value of zero also marks the slot as empty.

When a branch resolves, the back end reports the same pair address, the outcome, the real destination, and whether the pair actually contained a control transfer. The buffer moves the counter toward the outcome. A first taken branch with no entry gets a new entry at full taken confidence. A fall-through branch with no entry leaves no trace. An entry that predicted a redirect for a pair with no control transfer loses confidence. While an earlier misprediction is still flushing the pipe, redirects are held off, but updates continue as normal.

Top module: `btb_core`

## Requirements
- R1: A synchronous active-high reset clears every counter to 0. During reset, and in the cycle after it, `rsp_valid`, `rsp_hit` and `rsp_taken` are 0, and every lookup misses until something is allocated.
- R2: The set is chosen by address bits 5:0 and the tag is address bits 31:6. An address 64 bytes away (same set, different tag) misses. Entries in other sets are never disturbed.
- R3: The response is registered. `rsp_*` reflect a lookup in the cycle after `lk_valid`. `rsp_valid`, `rsp_hit` and `rsp_taken` are 0 after a cycle with no lookup, and `rsp_target` is 0 whenever `rsp_hit` is 0.
- R4: A lookup hits only when the tag matches a way whose counter is not 0. It predicts taken only when that counter is 2 or 3. A hit in state 1 reports `rsp_hit`=1, `rsp_taken`=0.
- R5: An update for a real control transfer that hits increments the counter on taken, saturating at 3, and rewrites the target. On fall-through it decrements the counter, saturating at 0.
- R6: A fall-through update with no live entry allocates nothing. An entry decremented to 0 is treated as absent.
- R7: A taken update with no live entry allocates a way with counter 3 and the given target. The counter never moves from 0 to 1.
- R8: A victim is the lowest-numbered way in the set whose counter is 0. If no such way exists, the victim is the way given by bits 1:0 of an 8-bit LFSR. The LFSR is seeded to 0x01 by reset and, every non-reset cycle, shifts left with new bit 0 = q[7]^q[5]^q[4]^q[3].
- R9: A lookup made with `flush_active`=1 returns `rsp_taken`=0, while `rsp_hit` and `rsp_target` are still reported. Updates in such cycles take effect normally.
- R10: An update with `up_is_cti`=0 decrements a matching entry whose counter is 2 or 3. It leaves a counter of 1 unchanged and never allocates.
- R11: When a lookup and an update occur in the same cycle, the lookup sees the entry after that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Pair address to look up |
| flush_active | input | 1 | Pipeline flush in progress; blocks taken predictions |
| up_valid | input | 1 | Resolution update request |
| up_addr | input | 32 | Pair address of the resolved branch |
| up_is_cti | input | 1 | Pair really held a control transfer |
| up_taken | input | 1 | Resolved outcome was taken |
| up_target | input | 32 | Resolved destination |
| rsp_valid | output | 1 | Response corresponds to last cycle's lookup |
| rsp_hit | output | 1 | Live entry found |
| rsp_taken | output | 1 | Redirect predicted |
| rsp_target | output | 32 | Predicted destination (0 on miss) |

## Verification
The assertions watch, on every clock, the timing shape of the response and the reset behaviour. They check that a redirect never appears without a hit, that a lookup under flush never redirects, and that a taken update bypassed into a same-cycle lookup of the same address yields a redirect to the new target. The counter walk, the asymmetric allocation, the choice of invalid ways before LFSR victims, eviction in a full set, and the confidence loss from pairs with no control transfer depend on history. Only the bench's scenarios can show these, by comparing each cycle against a behavioural model of the buffer.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic [1:0] {
        CNT_STRONG_FALL = 2'd0,
        CNT_WEAK_FALL   = 2'd1,
        CNT_WEAK_TAKE   = 2'd2,
        CNT_STRONG_TAKE = 2'd3
    } conf_t;

    function automatic logic [1:0] conf_up(input logic [1:0] c);
        return (c == CNT_STRONG_TAKE) ? c : c + 2'd1;
    endfunction

    function automatic logic [1:0] conf_down(input logic [1:0] c);
        return (c == CNT_STRONG_FALL) ? c : c - 2'd1;
    endfunction

    function automatic logic conf_redirects(input logic [1:0] c);
        return c[1];
    endfunction

    function automatic logic conf_live(input logic [1:0] c);
        return c != CNT_STRONG_FALL;
    endfunction

endpackage

// File: rtl/btb_lfsr.sv
module btb_lfsr #(
    parameter int          WIDTH = 8,
    parameter logic [7:0]  TAPS  = 8'hB8,
    parameter logic [7:0]  SEED  = 8'h01
) (
    input  logic             clk,
    input  logic             rst,
    output logic [WIDTH-1:0] q
);
    logic fb;

    always_comb fb = ^(q & TAPS[WIDTH-1:0]);

    always_ff @(posedge clk) begin
        if (rst) q <= SEED[WIDTH-1:0];
        else     q <= {q[WIDTH-2:0], fb};
    end
endmodule

// File: rtl/btb_set_update.sv
module btb_set_update
    import btb_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int TAG_W    = 26,
    parameter int WAYS     = 4,
    parameter int WAY_BITS = 2
) (
    input  logic [TAG_W-1:0]    cur_tag [WAYS],
    input  logic [ADDR_W-1:0]   cur_tgt [WAYS],
    input  logic [1:0]          cur_cnt [WAYS],
    input  logic [TAG_W-1:0]    up_tag,
    input  logic                up_is_cti,
    input  logic                up_taken,
    input  logic [ADDR_W-1:0]   up_target,
    input  logic [WAY_BITS-1:0] rnd_way,
    output logic [TAG_W-1:0]    nxt_tag [WAYS],
    output logic [ADDR_W-1:0]   nxt_tgt [WAYS],
    output logic [1:0]          nxt_cnt [WAYS]
);
    logic [WAYS-1:0]     match;
    logic [WAYS-1:0]     empty;
    logic [WAY_BITS-1:0] hit_way;
    logic [WAY_BITS-1:0] free_way;
    logic [WAY_BITS-1:0] victim;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = conf_live(cur_cnt[w]) && (cur_tag[w] == up_tag);
        assign empty[w] = !conf_live(cur_cnt[w]);
    end

    always_comb begin
        hit_way  = '0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way  = WAY_BITS'(w);
            if (empty[w]) free_way = WAY_BITS'(w);
        end
        victim = (|empty) ? free_way : rnd_way;
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            nxt_tag[w] = cur_tag[w];
            nxt_tgt[w] = cur_tgt[w];
            nxt_cnt[w] = cur_cnt[w];
        end
        if (|match) begin
            if (up_is_cti) begin
                if (up_taken) begin
                    nxt_cnt[hit_way] = conf_up(cur_cnt[hit_way]);
                    nxt_tgt[hit_way] = up_target;
                end else begin
                    nxt_cnt[hit_way] = conf_down(cur_cnt[hit_way]);
                end
            end else if (conf_redirects(cur_cnt[hit_way])) begin
                nxt_cnt[hit_way] = conf_down(cur_cnt[hit_way]);
            end
        end else if (up_is_cti && up_taken) begin
            nxt_tag[victim] = up_tag;
            nxt_tgt[victim] = up_target;
            nxt_cnt[victim] = CNT_STRONG_TAKE;
        end
    end
endmodule

// File: rtl/btb_set_lookup.sv
module btb_set_lookup
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 26,
    parameter int WAYS   = 4
) (
    input  logic [TAG_W-1:0]  way_tag [WAYS],
    input  logic [ADDR_W-1:0] way_tgt [WAYS],
    input  logic [1:0]        way_cnt [WAYS],
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              hit,
    output logic              taken,
    output logic [ADDR_W-1:0] target
);
    always_comb begin
        hit    = 1'b0;
        taken  = 1'b0;
        target = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (conf_live(way_cnt[w]) && way_tag[w] == lk_tag) begin
                hit    = 1'b1;
                taken  = conf_redirects(way_cnt[w]);
                target = way_tgt[w];
            end
        end
    end
endmodule

// File: rtl/btb_core.sv
module btb_core
    import btb_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int SET_BITS = 6,
    parameter int WAYS     = 4,
    parameter int LFSR_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              flush_active,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic              up_is_cti,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_target,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_taken,
    output logic [ADDR_W-1:0] rsp_target
);
    localparam int SETS     = 1 << SET_BITS;
    localparam int TAG_W    = ADDR_W - SET_BITS;
    localparam int WAY_BITS = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [TAG_W-1:0]  tag_q [SETS][WAYS];
    logic [ADDR_W-1:0] tgt_q [SETS][WAYS];
    logic [1:0]        cnt_q [SETS][WAYS];

    logic [SET_BITS-1:0] up_set, lk_set;
    logic [TAG_W-1:0]    up_tag, lk_tag;
    logic [LFSR_W-1:0]   lfsr_q;

    logic [TAG_W-1:0]  upd_tag_cur [WAYS], upd_tag_nxt [WAYS], view_tag [WAYS];
    logic [ADDR_W-1:0] upd_tgt_cur [WAYS], upd_tgt_nxt [WAYS], view_tgt [WAYS];
    logic [1:0]        upd_cnt_cur [WAYS], upd_cnt_nxt [WAYS], view_cnt [WAYS];

    logic              l_hit, l_taken;
    logic [ADDR_W-1:0] l_target;
    logic              bypass;

    assign up_set = up_addr[SET_BITS-1:0];
    assign up_tag = up_addr[ADDR_W-1:SET_BITS];
    assign lk_set = lk_addr[SET_BITS-1:0];
    assign lk_tag = lk_addr[ADDR_W-1:SET_BITS];
    assign bypass = up_valid && (up_set == lk_set);

    btb_lfsr #(.WIDTH(LFSR_W)) u_lfsr (
        .clk (clk),
        .rst (rst),
        .q   (lfsr_q)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign upd_tag_cur[w] = tag_q[up_set][w];
        assign upd_tgt_cur[w] = tgt_q[up_set][w];
        assign upd_cnt_cur[w] = cnt_q[up_set][w];
        assign view_tag[w] = bypass ? upd_tag_nxt[w] : tag_q[lk_set][w];
        assign view_tgt[w] = bypass ? upd_tgt_nxt[w] : tgt_q[lk_set][w];
        assign view_cnt[w] = bypass ? upd_cnt_nxt[w] : cnt_q[lk_set][w];
    end

    btb_set_update #(
        .ADDR_W(ADDR_W), .TAG_W(TAG_W), .WAYS(WAYS), .WAY_BITS(WAY_BITS)
    ) u_update (
        .cur_tag   (upd_tag_cur),
        .cur_tgt   (upd_tgt_cur),
        .cur_cnt   (upd_cnt_cur),
        .up_tag    (up_tag),
        .up_is_cti (up_is_cti),
        .up_taken  (up_taken),
        .up_target (up_target),
        .rnd_way   (lfsr_q[WAY_BITS-1:0]),
        .nxt_tag   (upd_tag_nxt),
        .nxt_tgt   (upd_tgt_nxt),
        .nxt_cnt   (upd_cnt_nxt)
    );

    btb_set_lookup #(
        .ADDR_W(ADDR_W), .TAG_W(TAG_W), .WAYS(WAYS)
    ) u_lookup (
        .way_tag (view_tag),
        .way_tgt (view_tgt),
        .way_cnt (view_cnt),
        .lk_tag  (lk_tag),
        .hit     (l_hit),
        .taken   (l_taken),
        .target  (l_target)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    cnt_q[s][w] <= CNT_STRONG_FALL;
        end else if (up_valid) begin
            for (int w = 0; w < WAYS; w++) begin
                tag_q[up_set][w] <= upd_tag_nxt[w];
                tgt_q[up_set][w] <= upd_tgt_nxt[w];
                cnt_q[up_set][w] <= upd_cnt_nxt[w];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_taken  <= 1'b0;
            rsp_target <= '0;
        end else begin
            rsp_valid  <= lk_valid;
            rsp_hit    <= lk_valid && l_hit;
            rsp_taken  <= lk_valid && l_hit && l_taken && !flush_active;
            rsp_target <= (lk_valid && l_hit) ? l_target : '0;
        end
    end
endmodule

// File: rtl/btb_core_chk.sv
module btb_core_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              flush_active,
    input logic              up_valid,
    input logic [ADDR_W-1:0] up_addr,
    input logic              up_is_cti,
    input logic              up_taken,
    input logic [ADDR_W-1:0] up_target,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_taken,
    input logic [ADDR_W-1:0] rsp_target
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rsp_valid && !rsp_hit && !rsp_taken);

    // R3
    idle_response_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid && !rsp_hit && !rsp_taken);

    // R4
    taken_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_taken |-> rsp_hit && rsp_valid);

    // R9
    flush_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid && flush_active |=> !rsp_taken);

    // R11
    bypass_taken_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid && !flush_active && up_valid && up_is_cti && up_taken
        && lk_addr == up_addr
        |=> rsp_hit && rsp_taken && rsp_target == $past(up_target));
endmodule

bind btb_core btb_core_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_btb_core.sv
module tb_btb_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        flush_active = 1'b0;
    logic        up_valid = 1'b0;
    logic [31:0] up_addr = '0;
    logic        up_is_cti = 1'b0;
    logic        up_taken = 1'b0;
    logic [31:0] up_target = '0;
    logic        rsp_valid, rsp_hit, rsp_taken;
    logic [31:0] rsp_target;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    btb_core dut (.*);

    // behavioural model
    int unsigned m_tag [64][4];
    int unsigned m_tgt [64][4];
    int          m_cnt [64][4];
    bit [7:0]    m_lfsr;
    bit          e_valid, e_hit, e_taken;
    int unsigned e_target;

    task automatic model_eval();
        int s, hw, vic;
        int unsigned t;
        if (rst) begin
            foreach (m_cnt[i, j]) m_cnt[i][j] = 0;
            m_lfsr = 8'h01;
            e_valid = 0; e_hit = 0; e_taken = 0; e_target = 0;
            return;
        end
        if (up_valid) begin
            s = int'(up_addr[5:0]); t = up_addr[31:6]; hw = -1;
            for (int w = 0; w < 4; w++)
                if (m_cnt[s][w] != 0 && m_tag[s][w] == t) begin hw = w; break; end
            if (hw >= 0) begin
                if (up_is_cti) begin
                    if (up_taken) begin
                        if (m_cnt[s][hw] < 3) m_cnt[s][hw]++;
                        m_tgt[s][hw] = up_target;
                    end else if (m_cnt[s][hw] > 0) m_cnt[s][hw]--;
                end else if (m_cnt[s][hw] >= 2) m_cnt[s][hw]--;
            end else if (up_is_cti && up_taken) begin
                vic = -1;
                for (int w = 0; w < 4; w++)
                    if (m_cnt[s][w] == 0) begin vic = w; break; end
                if (vic < 0) vic = int'(m_lfsr[1:0]);
                m_tag[s][vic] = t; m_tgt[s][vic] = up_target; m_cnt[s][vic] = 3;
            end
        end
        e_valid = lk_valid; e_hit = 0; e_taken = 0; e_target = 0;
        if (lk_valid) begin
            s = int'(lk_addr[5:0]); t = lk_addr[31:6];
            for (int w = 0; w < 4; w++)
                if (m_cnt[s][w] != 0 && m_tag[s][w] == t) begin
                    e_hit = 1; e_taken = (m_cnt[s][w] >= 2) && !flush_active;
                    e_target = m_tgt[s][w];
                end
        end
        m_lfsr = {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
    endtask

    task automatic check(string req, string what, int unsigned act, int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        model_eval();
        @(posedge clk);
        @(negedge clk);
        check(cur_req, "model rsp_valid", rsp_valid, e_valid);
        check(cur_req, "model rsp_hit", rsp_hit, e_hit);
        check(cur_req, "model rsp_taken", rsp_taken, e_taken);
        check(cur_req, "model rsp_target", rsp_target, e_target);
        lk_valid = 0; up_valid = 0; flush_active = 0;
    endtask

    task automatic upd(logic [31:0] a, bit cti, bit tk, logic [31:0] tg);
        up_valid = 1; up_addr = a; up_is_cti = cti; up_taken = tk; up_target = tg;
        step();
    endtask

    task automatic look(logic [31:0] a, bit fl);
        lk_valid = 1; lk_addr = a; flush_active = fl;
        step();
    endtask

    task automatic expect_rsp(string req, bit h, bit tk, logic [31:0] tg);
        check(req, "rsp_hit", rsp_hit, h);
        check(req, "rsp_taken", rsp_taken, tk);
        check(req, "rsp_target", rsp_target, tg);
    endtask

    localparam logic [31:0] A = 32'h0000_1004;   // set 4
    localparam logic [31:0] B = 32'h0000_1044;   // set 4, other tag
    localparam logic [31:0] C = 32'h0000_1005;   // set 5, same tag as A

    initial begin
        int hits;
        repeat (3) step();
        check("R1", "rsp_valid in reset", rsp_valid, 0);
        rst = 0;
        look(A, 0);
        cur_req = "R1"; expect_rsp("R1", 0, 0, 0);
        check("R3", "rsp_valid after lookup", rsp_valid, 1);
        step();
        check("R3", "rsp_valid idle", rsp_valid, 0);

        cur_req = "R6";
        upd(A, 1, 0, 32'hAAAA_0000);
        look(A, 0); expect_rsp("R6", 0, 0, 0);

        cur_req = "R7";
        upd(A, 1, 1, 32'h0000_2000);
        look(A, 0); expect_rsp("R7", 1, 1, 32'h0000_2000);
        cur_req = "R2";
        look(B, 0); expect_rsp("R2", 0, 0, 0);
        look(C, 0); expect_rsp("R2", 0, 0, 0);

        cur_req = "R5";
        upd(A, 1, 0, 0);                               // 3 -> 2
        look(A, 0); expect_rsp("R5", 1, 1, 32'h0000_2000);
        upd(A, 1, 0, 0);                               // 2 -> 1
        look(A, 0); expect_rsp("R4", 1, 0, 32'h0000_2000);
        upd(A, 1, 0, 0);                               // 1 -> 0
        look(A, 0); expect_rsp("R6", 0, 0, 0);
        upd(A, 1, 0, 0);
        look(A, 0); expect_rsp("R6", 0, 0, 0);
        cur_req = "R7";
        upd(A, 1, 1, 32'h0000_3000);                   // 0 -> 3, not 1
        upd(A, 1, 0, 0);                               // 3 -> 2
        look(A, 0); expect_rsp("R7", 1, 1, 32'h0000_3000);

        cur_req = "R5";
        repeat (3) upd(A, 1, 1, 32'h0000_4000);        // saturate at 3
        upd(A, 1, 0, 0);
        look(A, 0); expect_rsp("R5", 1, 1, 32'h0000_4000);

        cur_req = "R9";
        look(A, 1); expect_rsp("R9", 1, 0, 32'h0000_4000);
        lk_valid = 1; lk_addr = A; flush_active = 1;
        up_valid = 1; up_addr = A; up_is_cti = 1; up_taken = 1; up_target = 32'h0000_5000;
        step(); expect_rsp("R9", 1, 0, 32'h0000_5000);
        look(A, 0); expect_rsp("R9", 1, 1, 32'h0000_5000);

        cur_req = "R10";
        upd(A, 0, 1, 0);                               // 3 -> 2
        look(A, 0); expect_rsp("R10", 1, 1, 32'h0000_5000);
        upd(A, 0, 1, 0);                               // 2 -> 1
        look(A, 0); expect_rsp("R10", 1, 0, 32'h0000_5000);
        upd(A, 0, 1, 0);                               // stays 1
        look(A, 0); expect_rsp("R10", 1, 0, 32'h0000_5000);
        upd(B, 0, 1, 32'h1);                           // no allocation
        look(B, 0); expect_rsp("R10", 0, 0, 0);

        cur_req = "R11";
        lk_valid = 1; lk_addr = B;
        up_valid = 1; up_addr = B; up_is_cti = 1; up_taken = 1; up_target = 32'h0000_6000;
        step(); expect_rsp("R11", 1, 1, 32'h0000_6000);

        cur_req = "R8";
        for (int k = 0; k < 5; k++) upd(32'h0002_0007 + (k << 6), 1, 1, 32'h100 + k);
        hits = 0;
        for (int k = 0; k < 5; k++) begin
            look(32'h0002_0007 + (k << 6), 0);
            hits += int'(rsp_hit);
            if (k == 4) expect_rsp("R8", 1, 1, 32'h104);
        end
        check("R8", "live entries in full set", hits, 4);

        cur_req = "R11";
        for (int n = 0; n < 2000; n++) begin
            int unsigned ls, us;
            ls = ($urandom % 2) ? 3 : 17;
            us = ($urandom % 2) ? 3 : 17;
            lk_valid = ($urandom % 4) != 0;
            lk_addr = ((($urandom % 7) + 32'h40) << 6) | ls;
            flush_active = ($urandom % 5) == 0;
            up_valid = ($urandom % 3) != 0;
            up_addr = ((($urandom % 7) + 32'h40) << 6) | us;
            up_is_cti = ($urandom % 5) != 0;
            up_taken = $urandom % 2;
            up_target = $urandom;
            step();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule